// File: doc/BRIEF.md
# Per-Core Local Tick Timer Bank

A bank of identical timers, one for each processor core, each reached through its own 256-byte window on a 32-bit register bus. A timer divides the input clock with a tick prescaler: while running, it emits one tick every (tick divisor + 1) clocks. A second stage, the event down-counter, counts those ticks and flags an expiry when a tick arrives while the count is already zero. On expiry the counter reloads from its reload register. The timer then either stops (one-shot) or keeps firing at a fixed period (interval mode).

Each timer drives its own interrupt line from a sticky, write-one-to-clear status bit gated by an enable bit. A set of sticky write-acknowledge flags records that a write to the divisor, reload or control register has landed. Software can poll those flags before relying on the new value. The bus reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `ltt_bank`

## Requirements
- R1: Timer n (n from 0 to N_TIMERS-1) answers at byte addresses 0x300 + 0x100*n; the low address byte selects the register: divisor 0x00, reload 0x08, control 0x20, status 0x30, enable 0x34, write-acknowledge 0x40. Any other address reads 0, and writes to it change nothing.
- R2: After reset every register reads 0 and every interrupt line is low.
- R3: While control bit 0 (tick run) is 1, a tick occurs once every (divisor+1) clocks; while it is 0, no tick occurs and the prescaler restarts from zero.
- R4: A write to the reload register with bit 31 set loads bits 30:0 into both the reload register and the live count. With bit 31 clear, both are left unchanged. Reading the reload register returns the reload value with bit 31 as 0.
- R5: While control bits 0 and 1 (tick run, count run) are both 1, each tick decrements the count. A tick that finds the count at zero is an expiry: it sets status bit 0 and reloads the count. An expiry therefore falls (count+1)*(divisor+1) clock edges after both run bits are written.
- R6: With control bit 2 (interval) at 0, an expiry clears control bit 1, and no further expiry follows.
- R7: With control bit 2 at 1, control bit 1 stays set across expiries, and expiries repeat every (reload+1)*(divisor+1) clocks.
- R8: Writing 1 to status bit 0 clears it. An expiry in the same cycle wins over the clear.
- R9: Each timer's interrupt line is high exactly when its status bit 0 and enable bit 0 are both 1.
- R10: Write-acknowledge bits 0, 1 and 3 become 1 after any write to the divisor, reload and control registers respectively. Writing 1 to a bit clears it.
- R11: Timers are independent: traffic to one window changes no other timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | N_TIMERS | One interrupt line per timer |

## Verification
Read data depends only on the address in the same cycle. A register write is visible from the clock edge that accepts it. The bench therefore drives inputs on the falling edge and samples reads shortly after. An expiry lands exactly (count+1)*(divisor+1) rising edges after the edge that starts both run bits, and the interrupt rises on that same edge. Directed checks count falling edges from the control write and compare the count with that product. A behavioural model steps every timer on every rising edge and is compared with all interrupt lines on every falling edge, so an early or late expiry of even one cycle is caught.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
  localparam int WIN_PAGE0 = 3;
  localparam int RELOAD_W  = 31;
  localparam logic [7:0] OFS_DIV = 8'h00;
  localparam logic [7:0] OFS_RLD = 8'h08;
  localparam logic [7:0] OFS_CTL = 8'h20;
  localparam logic [7:0] OFS_STS = 8'h30;
  localparam logic [7:0] OFS_ENA = 8'h34;
  localparam logic [7:0] OFS_ACK = 8'h40;

  typedef struct packed {
    logic interval;
    logic cnt_run;
    logic tick_run;
  } ctl_t;
endpackage

// File: rtl/ltt_prescaler.sv
module ltt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    tick   = run && (pcnt_q >= limit);
    pcnt_d = (!run || tick) ? '0 : pcnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/ltt_evcounter.sv
module ltt_evcounter #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = step && (cnt_q == '0);
    if (load)        cnt_d = load_val;
    else if (expire) cnt_d = reload_val;
    else if (step)   cnt_d = cnt_q - W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ltt_channel.sv
module ltt_channel
  import ltt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [7:0]  ofs,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        expire,
  output logic        sts,
  output logic        cnt_run,
  output logic        interval
);
  logic [31:0]         div_q, div_d;
  logic [RELOAD_W-1:0] rld_q, rld_d;
  ctl_t                ctl_q, ctl_d;
  logic                sts_q, sts_d, ena_q, ena_d;
  logic [2:0]          ack_q, ack_d;
  logic                wr_div, wr_rld, wr_ctl, wr_sts, wr_ena, wr_ack;
  logic                tick, step, rld_load;

  always_comb begin
    wr_div   = sel && wr && (ofs == OFS_DIV);
    wr_rld   = sel && wr && (ofs == OFS_RLD);
    wr_ctl   = sel && wr && (ofs == OFS_CTL);
    wr_sts   = sel && wr && (ofs == OFS_STS);
    wr_ena   = sel && wr && (ofs == OFS_ENA);
    wr_ack   = sel && wr && (ofs == OFS_ACK);
    rld_load = wr_rld && wdata[31];
    step     = tick && ctl_q.cnt_run;
  end

  ltt_prescaler #(.W(32)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.tick_run), .limit(div_q), .tick(tick)
  );

  ltt_evcounter #(.W(RELOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(rld_load),
    .load_val(wdata[RELOAD_W-1:0]), .reload_val(rld_q), .expire(expire)
  );

  always_comb begin
    div_d = wr_div   ? wdata : div_q;
    rld_d = rld_load ? wdata[RELOAD_W-1:0] : rld_q;
    ctl_d = ctl_q;
    if (wr_ctl)                          ctl_d = ctl_t'(wdata[2:0]);
    else if (expire && !ctl_q.interval)  ctl_d.cnt_run = 1'b0;
    sts_d = expire | (sts_q & ~(wr_sts & wdata[0]));
    ena_d = wr_ena ? wdata[0] : ena_q;
    ack_d = ack_q;
    if (wr_ack) ack_d = ack_q & ~{wdata[3], wdata[1], wdata[0]};
    if (wr_div) ack_d[0] = 1'b1;
    if (wr_rld) ack_d[1] = 1'b1;
    if (wr_ctl) ack_d[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
      sts_q <= 1'b0;
      ena_q <= 1'b0;
      ack_q <= '0;
    end else begin
      div_q <= div_d;
      rld_q <= rld_d;
      ctl_q <= ctl_d;
      sts_q <= sts_d;
      ena_q <= ena_d;
      ack_q <= ack_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (ofs)
        OFS_DIV: rdata = div_q;
        OFS_RLD: rdata = {1'b0, rld_q};
        OFS_CTL: rdata = {29'd0, ctl_q};
        OFS_STS: rdata = {31'd0, sts_q};
        OFS_ENA: rdata = {31'd0, ena_q};
        OFS_ACK: rdata = {28'd0, ack_q[2], 1'b0, ack_q[1], ack_q[0]};
        default: rdata = '0;
      endcase
    end
  end

  assign irq      = sts_q & ena_q;
  assign sts      = sts_q;
  assign cnt_run  = ctl_q.cnt_run;
  assign interval = ctl_q.interval;
endmodule

// File: rtl/ltt_bank.sv
module ltt_bank
  import ltt_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [N_TIMERS-1:0] irq
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [1:0]          rst_sync_q;
  logic                core_rst_n;
  logic [PAGE_W-1:0]   page;
  logic [31:0]         ch_rdata [N_TIMERS];
  logic [N_TIMERS-1:0] exp_v, sts_v, run_v, ival_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];
  assign page       = bus_addr[ADDR_W-1:8];

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
    logic sel;
    assign sel = (page == PAGE_W'(WIN_PAGE0 + i));
    ltt_channel u_ch (
      .clk(clk), .rst_n(core_rst_n), .sel(sel), .wr(bus_wr),
      .ofs(bus_addr[7:0]), .wdata(bus_wdata), .rdata(ch_rdata[i]),
      .irq(irq[i]), .expire(exp_v[i]), .sts(sts_v[i]),
      .cnt_run(run_v[i]), .interval(ival_v[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_TIMERS; i++) bus_rdata = bus_rdata | ch_rdata[i];
  end
endmodule

// File: rtl/ltt_bank_chk.sv
module ltt_bank_chk
  import ltt_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                wd0,
  input logic [31:0]         bus_rdata,
  input logic [N_TIMERS-1:0] exp_v,
  input logic [N_TIMERS-1:0] sts_v,
  input logic [N_TIMERS-1:0] run_v,
  input logic [N_TIMERS-1:0] ival_v
);
  localparam int PW = ADDR_W - 8;

  // R1
  low_page_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:8] < PW'(WIN_PAGE0)) |-> (bus_rdata == 32'd0));

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_t
    logic hit_sts, hit_ctl;
    assign hit_sts = bus_wr && (bus_addr[ADDR_W-1:8] == PW'(WIN_PAGE0 + i)) && (bus_addr[7:0] == OFS_STS);
    assign hit_ctl = bus_wr && (bus_addr[ADDR_W-1:8] == PW'(WIN_PAGE0 + i)) && (bus_addr[7:0] == OFS_CTL);

    // R5
    expire_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] |=> sts_v[i]);
    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_sts && wd0 && !exp_v[i]) |=> !sts_v[i]);
    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_v[i] && !ival_v[i] && !hit_ctl) |=> !run_v[i]);
    // R7
    interval_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_v[i] && ival_v[i] && !hit_ctl) |=> run_v[i]);
  end
endmodule

bind ltt_bank ltt_bank_chk #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd0(bus_wdata[0]), .bus_rdata(bus_rdata), .exp_v(exp_v),
  .sts_v(sts_v), .run_v(run_v), .ival_v(ival_v)
);

// File: tb/ltt_bank_test.sv
`timescale 1ns/1ps
module ltt_bank_test;
  localparam int N = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ltt_bank #(.N_TIMERS(N), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model, stepped on every rising edge
  logic [31:0] m_div [N], m_pc [N], m_rld [N], m_cnt [N];
  logic [2:0]  m_ctl [N];
  logic        m_sts [N], m_ena [N];
  logic [3:0]  m_ack [N];

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        m_div[i] = 0; m_pc[i] = 0; m_rld[i] = 0; m_cnt[i] = 0;
        m_ctl[i] = 0; m_sts[i] = 0; m_ena[i] = 0; m_ack[i] = 0;
      end else begin
        bit hit, tk, st, ex;
        logic [7:0] o;
        hit = bus_wr && (bus_addr[11:8] == 4'(3 + i));
        o   = bus_addr[7:0];
        tk  = m_ctl[i][0] && (m_pc[i] >= m_div[i]);
        st  = tk && m_ctl[i][1];
        ex  = st && (m_cnt[i] == 0);
        m_pc[i] = (!m_ctl[i][0] || tk) ? 0 : m_pc[i] + 1;
        if (hit && o == 8'h08 && bus_wdata[31]) m_cnt[i] = {1'b0, bus_wdata[30:0]};
        else if (ex) m_cnt[i] = m_rld[i];
        else if (st) m_cnt[i] = m_cnt[i] - 1;
        if (hit && o == 8'h08 && bus_wdata[31]) m_rld[i] = {1'b0, bus_wdata[30:0]};
        if (hit && o == 8'h00) m_div[i] = bus_wdata;
        if (hit && o == 8'h20) m_ctl[i] = bus_wdata[2:0];
        else if (ex && !m_ctl[i][2]) m_ctl[i][1] = 1'b0;
        if (ex) m_sts[i] = 1'b1;
        else if (hit && o == 8'h30 && bus_wdata[0]) m_sts[i] = 1'b0;
        if (hit && o == 8'h34) m_ena[i] = bus_wdata[0];
        if (hit && o == 8'h40) m_ack[i] = m_ack[i] & ~{bus_wdata[3], 1'b0, bus_wdata[1:0]};
        if (hit && o == 8'h00) m_ack[i][0] = 1'b1;
        if (hit && o == 8'h08) m_ack[i][1] = 1'b1;
        if (hit && o == 8'h20) m_ack[i][3] = 1'b1;
      end
    end
  end

  // R9: every interrupt line against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done)
      for (int i = 0; i < N; i++)
        chk(irq[i] === (m_sts[i] & m_ena[i]), "R9 model irq", 32'(irq[i]), 32'(m_sts[i] & m_ena[i]));
  end

  // tasks start and end on a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic wait_irq(input int idx, output int n);
    n = 0;
    while (!irq[idx] && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 reset state
    for (int i = 0; i < N; i++) begin
      rdchk(12'(12'h300 + 12'h100 * i + 12'h00), 32'h0, "R2 divisor");
      rdchk(12'(12'h300 + 12'h100 * i + 12'h20), 32'h0, "R2 control");
      rdchk(12'(12'h300 + 12'h100 * i + 12'h30), 32'h0, "R2 status");
      rdchk(12'(12'h300 + 12'h100 * i + 12'h40), 32'h0, "R2 write-ack");
    end
    chk(irq === '0, "R2 irq", 32'(irq), 32'h0);

    // R1 decode
    wr(12'h400, 32'd5);
    rdchk(12'h400, 32'd5, "R1 timer1 divisor");
    rdchk(12'h300, 32'd0, "R1 timer0 divisor untouched");
    rdchk(12'h410, 32'd0, "R1 unmapped offset");
    wr(12'h200, 32'hFFFF_FFFF);
    rdchk(12'h200, 32'd0, "R1 below first window");
    wr(12'h708, 32'h8000_0009);
    rdchk(12'h708, 32'd0, "R1 absent timer");
    rdchk(12'h608, 32'd0, "R1 timer3 reload untouched");

    // R3 tick stopped, then divisor period on timer1
    wr(12'h408, 32'h8000_0000);
    wr(12'h434, 32'd1);
    wr(12'h420, 32'h2);
    repeat (30) @(negedge clk);
    chk(irq[1] === 1'b0, "R3 no tick while tick-run clear", 32'(irq[1]), 32'h0);
    wr(12'h420, 32'h3);
    wait_irq(1, n);
    chk(n == 6, "R3 divisor period", 32'(n), 32'd6);
    rdchk(12'h420, 32'h1, "R6 timer1 count-run cleared");
    wr(12'h430, 32'd1);

    // R5 R7 timer0 interval
    wr(12'h300, 32'd2);
    wr(12'h308, 32'h8000_0003);
    rdchk(12'h308, 32'h0000_0003, "R4 reload readback");
    wr(12'h334, 32'd1);
    wr(12'h320, 32'h7);
    wait_irq(0, n);
    chk(n == 12, "R5 first expiry", 32'(n), 32'd12);
    wr(12'h330, 32'd1);
    chk(irq[0] === 1'b0, "R8 status cleared", 32'(irq[0]), 32'h0);
    wait_irq(0, n);
    chk(n == 11, "R7 second expiry", 32'(n), 32'd11);
    rdchk(12'h320, 32'h7, "R7 control kept");
    wr(12'h320, 32'h0);
    wr(12'h330, 32'd1);

    // R6 one-shot on timer2 with interrupt masked
    wr(12'h500, 32'd0);
    wr(12'h508, 32'h8000_0004);
    wr(12'h520, 32'h3);
    repeat (5) @(negedge clk);
    rdchk(12'h530, 32'd1, "R6 status after one-shot");
    rdchk(12'h520, 32'h1, "R6 count-run cleared");
    chk(irq[2] === 1'b0, "R9 masked", 32'(irq[2]), 32'h0);
    wr(12'h534, 32'd1);
    chk(irq[2] === 1'b1, "R9 enabled", 32'(irq[2]), 32'h1);
    wr(12'h530, 32'd1);
    repeat (20) @(negedge clk);
    rdchk(12'h530, 32'd0, "R6 no second expiry");

    // R4 write without update flag
    wr(12'h508, 32'h0000_0007);
    rdchk(12'h508, 32'h0000_0004, "R4 no update without bit31");

    // R8 expiry wins over simultaneous clear
    wr(12'h508, 32'h8000_0000);
    wr(12'h520, 32'h3);
    wr(12'h530, 32'd1);
    rdchk(12'h530, 32'd1, "R8 set wins over clear");
    wr(12'h530, 32'd1);

    // R11 timer3 untouched
    rdchk(12'h620, 32'd0, "R11 timer3 control");
    rdchk(12'h640, 32'd0, "R11 timer3 write-ack");
    chk(irq[3] === 1'b0, "R11 timer3 irq", 32'(irq[3]), 32'h0);

    // R10 write-acknowledge
    wr(12'h600, 32'd9);
    rdchk(12'h640, 32'h1, "R10 divisor ack");
    wr(12'h608, 32'h0000_0001);
    rdchk(12'h640, 32'h3, "R10 reload ack");
    wr(12'h620, 32'h0);
    rdchk(12'h640, 32'hB, "R10 control ack");
    wr(12'h640, 32'h3);
    rdchk(12'h640, 32'h8, "R10 partial clear");
    wr(12'h640, 32'h8);
    rdchk(12'h640, 32'h0, "R10 full clear");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule